// File: doc/BRIEF.md
# Table Entry Aging Engine with Learned and Aged Event Queues

This block keeps the ageing state of a lookup table. It holds one 9-bit time stamp, a valid bit and a static bit for every entry. A free-running time counter advances on a prescaled tick. A port operation arrives as a request with an entry index from the matching logic. It either learns an entry, which writes it and stamps it, or reports a hit on an entry, which refreshes the stamp.

An ageing pass walks the table one entry per cycle. It invalidates every valid entry that is not static and whose age is above a programmable threshold. A pass starts on a command, or on every prescaler tick when automatic ageing is enabled. Walk steps and port operations share the table's single write slot, and a configuration bit decides which of the two wins.

The index of every learned entry goes into one 16-deep event queue, and the index of every aged-out entry goes into a second one. The host drains each queue through its own read strobe.

Top module: `entry_aging_engine`

## Requirements
- R1: After reset every entry is invalid, non-static and stamped 0. The time is 0, no pass is running, both queues are empty, both read-valid outputs are low and both overflow flags are clear.
- R2: `cur_time` is a 9-bit count that rises by one once every TICK_DIV clock cycles and wraps from 511 to 0.
- R3: A granted learn sets the entry valid, loads its static bit from `port_static` and loads its stamp with `cur_time`, all visible on the next cycle. In the same cycle its index is pushed to the learned queue.
- R4: A granted hit on a valid entry reloads its stamp with `cur_time`. A hit on an invalid entry changes nothing.
- R5: A pass checks entries in index order from 0 to ENTRIES-1, one per step, and `age_busy` is high from the cycle after it starts until the last step. A checked entry is invalidated when it is valid, not static, and (`cur_time` - stamp) mod 512 is strictly greater than `cfg_threshold`. Its index is then pushed to the aged queue.
- R6: A static entry is never invalidated by a pass, whatever its age.
- R7: When no pass is running, a pass starts on `cmd_age` or, with `cfg_auto_en` high, on a prescaler tick. A trigger that arrives while a pass is running is ignored.
- R8: While a pass runs with `cfg_auto_hi`=1, `port_gnt` is low and the walk advances every cycle. With `cfg_auto_hi`=0, a port request is granted and the walk holds its place for that cycle. With no pass running, every request is granted.
- R9: Each queue is first-in first-out. A read strobe on a non-empty queue returns the oldest index with its read-valid high on the next cycle.
- R10: A push into a full queue (16 entries at the start of the cycle) is dropped and sets that queue's overflow flag. The flag stays set until reset.
- R11: A read strobe on an empty queue gives read-valid low on the next cycle and leaves the queue contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto_en | input | 1 | Start a pass on each prescaler tick |
| cfg_auto_hi | input | 1 | 1: walk steps win over port requests |
| cfg_threshold | input | 9 | Age above which an entry is stale |
| cmd_age | input | 1 | Start a pass now if idle |
| port_req | input | 1 | Port operation request |
| port_learn | input | 1 | 1: learn, 0: hit |
| port_static | input | 1 | Static bit written by a learn |
| port_idx | input | IDX_W | Entry index of the port operation |
| port_gnt | output | 1 | Port operation accepted this cycle |
| qry_idx | input | IDX_W | Entry to observe |
| qry_valid | output | 1 | Valid bit of the observed entry |
| qry_static | output | 1 | Static bit of the observed entry |
| qry_stamp | output | 9 | Stamp of the observed entry |
| cur_time | output | 9 | Current time |
| age_busy | output | 1 | Ageing pass in progress |
| lrn_rd | input | 1 | Pop the learned queue |
| lrn_rdata | output | IDX_W | Popped learned index |
| lrn_rvalid | output | 1 | `lrn_rdata` holds a popped entry |
| lrn_ovf | output | 1 | Sticky learned-queue overflow |
| aged_rd | input | 1 | Pop the aged queue |
| aged_rdata | output | IDX_W | Popped aged index |
| aged_rvalid | output | 1 | `aged_rdata` holds a popped entry |
| aged_ovf | output | 1 | Sticky aged-queue overflow |

## Verification
The bench builds the block with ENTRIES=8, TICK_DIV=16 and QDEPTH=16. A walk then takes 8 cycles and finishes before the next tick. The 512-step time wrap takes 8192 cycles, so stamps that straddle the wrap are exercised inside a run of about 12,000 cycles. Sixteen-deep queues fill within tens of learns, which brings drops, sticky overflow, pushes into a full queue in the same cycle as a pop, and empty reads within reach. Both priority settings are used against dense port traffic, so the bench sees walks that stall and port requests that are refused.

// File: rtl/eae_pkg.sv
package eae_pkg;
   localparam int TIME_W = 9;
   typedef logic [TIME_W-1:0] stamp_t;
   typedef enum logic {OP_HIT = 1'b0, OP_LEARN = 1'b1} port_op_e;
endpackage

// File: rtl/eae_timebase.sv
module eae_timebase
   import eae_pkg::*;
#(
   parameter int TICK_DIV = 256
) (
   input  logic   clk,
   input  logic   rst_n,
   output logic   tick,
   output stamp_t now
);
   localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end

   generate
      if (TICK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [PW-1:0] pre_q;
         assign tick = (pre_q == PW'(TICK_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)    pre_q <= '0;
            else if (tick) pre_q <= '0;
            else           pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    now <= '0;
      else if (tick) now <= now + 1'b1;
   end
endmodule

// File: rtl/eae_event_fifo.sv
module eae_event_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          rd,
   output logic [DW-1:0] dout,
   output logic          dvalid,
   output logic          ovf
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   cnt_q;
   logic          full, pop, push_ok;

   assign full    = (cnt_q == (AW+1)'(DEPTH));
   assign pop     = rd && (cnt_q != '0);
   assign push_ok = push && !full;

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wp_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q   <= '0;
         rp_q   <= '0;
         cnt_q  <= '0;
         dout   <= '0;
         dvalid <= 1'b0;
         ovf    <= 1'b0;
      end else begin
         dvalid <= pop;
         if (pop) begin
            dout <= mem_q[rp_q];
            rp_q <= rp_q + 1'b1;
         end
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (push && full) ovf <= 1'b1;
         cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop);
      end
   end
endmodule

// File: rtl/eae_table.sv
module eae_table
   import eae_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int IW      = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  stamp_t        now,
   input  logic          wr_en,
   input  port_op_e      wr_op,
   input  logic          wr_static,
   input  logic [IW-1:0] wr_idx,
   input  logic          clr_en,
   input  logic [IW-1:0] chk_idx,
   output logic          chk_valid,
   output logic          chk_static,
   output stamp_t        chk_stamp,
   input  logic [IW-1:0] qry_idx,
   output logic          qry_valid,
   output logic          qry_static,
   output stamp_t        qry_stamp
);
   logic [ENTRIES-1:0] valid_q, stat_q;
   stamp_t             stamp_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         stat_q  <= '0;
         for (int e = 0; e < ENTRIES; e++) stamp_q[e] <= '0;
      end else begin
         if (clr_en) valid_q[chk_idx] <= 1'b0;
         if (wr_en) begin
            if (wr_op == OP_LEARN) begin
               valid_q[wr_idx] <= 1'b1;
               stat_q[wr_idx]  <= wr_static;
               stamp_q[wr_idx] <= now;
            end else if (valid_q[wr_idx]) begin
               stamp_q[wr_idx] <= now;
            end
         end
      end
   end

   assign chk_valid  = valid_q[chk_idx];
   assign chk_static = stat_q[chk_idx];
   assign chk_stamp  = stamp_q[chk_idx];
   assign qry_valid  = valid_q[qry_idx];
   assign qry_static = stat_q[qry_idx];
   assign qry_stamp  = stamp_q[qry_idx];
endmodule

// File: rtl/eae_walker.sv
module eae_walker
   import eae_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int IW      = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          auto_en,
   input  logic          auto_hi,
   input  logic          cmd,
   input  logic          port_req,
   input  stamp_t        now,
   input  stamp_t        thr,
   input  logic          chk_valid,
   input  logic          chk_static,
   input  stamp_t        chk_stamp,
   output logic          busy,
   output logic [IW-1:0] ptr,
   output logic          port_gnt,
   output logic          kill
);
   logic   start, step;
   stamp_t age;

   assign port_gnt = port_req && !(busy && auto_hi);
   assign step     = busy && (auto_hi || !port_req);
   assign age      = now - chk_stamp;
   assign kill     = step && chk_valid && !chk_static && (age > thr);
   assign start    = !busy && ((tick && auto_en) || cmd);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ptr  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         ptr  <= '0;
      end else if (step) begin
         ptr <= ptr + 1'b1;
         if (ptr == IW'(ENTRIES - 1)) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/entry_aging_engine.sv
module entry_aging_engine
   import eae_pkg::*;
#(
   parameter int ENTRIES  = 64,
   parameter int TICK_DIV = 256,
   parameter int QDEPTH   = 16,
   parameter int IDX_W    = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_auto_en,
   input  logic             cfg_auto_hi,
   input  logic [8:0]       cfg_threshold,
   input  logic             cmd_age,
   input  logic             port_req,
   input  logic             port_learn,
   input  logic             port_static,
   input  logic [IDX_W-1:0] port_idx,
   output logic             port_gnt,
   input  logic [IDX_W-1:0] qry_idx,
   output logic             qry_valid,
   output logic             qry_static,
   output logic [8:0]       qry_stamp,
   output logic [8:0]       cur_time,
   output logic             age_busy,
   input  logic             lrn_rd,
   output logic [IDX_W-1:0] lrn_rdata,
   output logic             lrn_rvalid,
   output logic             lrn_ovf,
   input  logic             aged_rd,
   output logic [IDX_W-1:0] aged_rdata,
   output logic             aged_rvalid,
   output logic             aged_ovf
);
   if (ENTRIES < 2 || IDX_W < $clog2(ENTRIES)) begin : g_bad_entries
      $error("ENTRIES must be at least 2 and fit in IDX_W");
   end

   logic             tick, age_kill, chk_valid, chk_static;
   stamp_t           now, chk_stamp, qstamp;
   logic [IDX_W-1:0] walk_ptr;
   port_op_e         op;

   assign op        = port_learn ? OP_LEARN : OP_HIT;
   assign cur_time  = now;
   assign qry_stamp = qstamp;

   eae_timebase #(.TICK_DIV(TICK_DIV)) u_time (
      .clk(clk), .rst_n(rst_n), .tick(tick), .now(now)
   );

   eae_walker #(.ENTRIES(ENTRIES), .IW(IDX_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .tick(tick), .auto_en(cfg_auto_en),
      .auto_hi(cfg_auto_hi), .cmd(cmd_age), .port_req(port_req),
      .now(now), .thr(cfg_threshold), .chk_valid(chk_valid),
      .chk_static(chk_static), .chk_stamp(chk_stamp), .busy(age_busy),
      .ptr(walk_ptr), .port_gnt(port_gnt), .kill(age_kill)
   );

   eae_table #(.ENTRIES(ENTRIES), .IW(IDX_W)) u_tab (
      .clk(clk), .rst_n(rst_n), .now(now), .wr_en(port_gnt), .wr_op(op),
      .wr_static(port_static), .wr_idx(port_idx), .clr_en(age_kill),
      .chk_idx(walk_ptr), .chk_valid(chk_valid), .chk_static(chk_static),
      .chk_stamp(chk_stamp), .qry_idx(qry_idx), .qry_valid(qry_valid),
      .qry_static(qry_static), .qry_stamp(qstamp)
   );

   eae_event_fifo #(.DEPTH(QDEPTH), .DW(IDX_W)) u_lrnq (
      .clk(clk), .rst_n(rst_n), .push(port_gnt && port_learn), .din(port_idx),
      .rd(lrn_rd), .dout(lrn_rdata), .dvalid(lrn_rvalid), .ovf(lrn_ovf)
   );

   eae_event_fifo #(.DEPTH(QDEPTH), .DW(IDX_W)) u_agedq (
      .clk(clk), .rst_n(rst_n), .push(age_kill), .din(walk_ptr),
      .rd(aged_rd), .dout(aged_rdata), .dvalid(aged_rvalid), .ovf(aged_ovf)
   );
endmodule

module eae_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_auto_en,
   input logic       cfg_auto_hi,
   input logic       cmd_age,
   input logic       port_req,
   input logic       age_busy,
   input logic [8:0] cur_time,
   input logic       lrn_rd,
   input logic       lrn_rvalid,
   input logic       lrn_ovf,
   input logic       aged_rd,
   input logic       aged_rvalid,
   input logic       aged_ovf,
   input logic       aged_push
);
   // R2
   time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_time) |-> cur_time == $past(cur_time) + 9'd1);
   // R5
   aged_push_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aged_push |-> age_busy);
   // R7
   pass_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(age_busy) |-> ($past(cmd_age) || $past(cfg_auto_en)));
   // R8
   walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_busy && !cfg_auto_hi && port_req) |=> age_busy);
   // R9
   lrn_rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lrn_rvalid |-> $past(lrn_rd));
   // R9
   aged_rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aged_rvalid |-> $past(aged_rd));
   // R10
   lrn_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lrn_ovf |=> lrn_ovf);
   // R10
   aged_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aged_ovf |=> aged_ovf);
endmodule

bind entry_aging_engine eae_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_auto_en(cfg_auto_en), .cfg_auto_hi(cfg_auto_hi),
   .cmd_age(cmd_age), .port_req(port_req), .age_busy(age_busy),
   .cur_time(cur_time), .lrn_rd(lrn_rd), .lrn_rvalid(lrn_rvalid),
   .lrn_ovf(lrn_ovf), .aged_rd(aged_rd), .aged_rvalid(aged_rvalid),
   .aged_ovf(aged_ovf), .aged_push(age_kill)
);

// File: tb/entry_aging_engine_tb.sv
module entry_aging_engine_tb_top;
   localparam int N  = 8;
   localparam int TD = 16;
   localparam int QD = 16;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_auto_en = 0, cfg_auto_hi = 0, cmd_age = 0;
   logic [8:0] cfg_threshold = 9'd1;
   logic port_req = 0, port_learn = 0, port_static = 0;
   logic [IW-1:0] port_idx = '0, qry_idx = '0;
   logic lrn_rd = 0, aged_rd = 0;
   logic port_gnt, qry_valid, qry_static, age_busy;
   logic [8:0] qry_stamp, cur_time;
   logic [IW-1:0] lrn_rdata, aged_rdata;
   logic lrn_rvalid, lrn_ovf, aged_rvalid, aged_ovf;

   int checks = 0, failures = 0;

   always #10 clk = ~clk;

   entry_aging_engine #(.ENTRIES(N), .TICK_DIV(TD), .QDEPTH(QD), .IDX_W(IW)) dut_i (.*);

   // reference model state
   int m_valid [N], m_stat [N], m_stamp [N];
   int m_pre, m_now, m_busy, m_ptr;
   int lq [$], aq [$];
   int m_lrv, m_lrd, m_arv, m_ard, m_lovf, m_aovf;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int e = 0; e < N; e++) begin
         m_valid[e] = 0; m_stat[e] = 0; m_stamp[e] = 0;
      end
      m_pre = 0; m_now = 0; m_busy = 0; m_ptr = 0;
      lq.delete(); aq.delete();
      m_lrv = 0; m_lrd = 0; m_arv = 0; m_ard = 0; m_lovf = 0; m_aovf = 0;
   endtask

   function automatic int exp_gnt();
      return (port_req && !(m_busy && cfg_auto_hi)) ? 1 : 0;
   endfunction

   // compare outputs against the model, then advance the model one clock
   task automatic cyc();
      int tick, gnt, step, ls, as_;
      #1;
      gnt = exp_gnt();
      chk("R8 port grant", int'(port_gnt), gnt);
      chk("R2 current time", int'(cur_time), m_now);
      chk("R5 busy", int'(age_busy), m_busy);
      chk("R5/R6 entry valid", int'(qry_valid), m_valid[qry_idx]);
      chk("R3 entry static", int'(qry_static), m_stat[qry_idx]);
      chk("R4 entry stamp", int'(qry_stamp), m_stamp[qry_idx]);
      chk("R9/R11 learned rvalid", int'(lrn_rvalid), m_lrv);
      if (m_lrv) chk("R9 learned data", int'(lrn_rdata), m_lrd);
      chk("R9/R11 aged rvalid", int'(aged_rvalid), m_arv);
      if (m_arv) chk("R9 aged data", int'(aged_rdata), m_ard);
      chk("R10 learned overflow", int'(lrn_ovf), m_lovf);
      chk("R10 aged overflow", int'(aged_ovf), m_aovf);

      tick = (m_pre == TD - 1);
      step = m_busy && (cfg_auto_hi || !port_req);
      ls = lq.size(); as_ = aq.size();
      // queue pops use the occupancy at the start of the cycle
      m_lrv = (lrn_rd && ls > 0);
      if (m_lrv) m_lrd = lq.pop_front();
      m_arv = (aged_rd && as_ > 0);
      if (m_arv) m_ard = aq.pop_front();
      if (step) begin
         if (m_valid[m_ptr] && !m_stat[m_ptr] &&
             (((m_now - m_stamp[m_ptr]) & 511) > int'(cfg_threshold))) begin
            m_valid[m_ptr] = 0;
            if (as_ >= QD) m_aovf = 1; else aq.push_back(m_ptr);
         end
      end
      if (gnt) begin
         if (port_learn) begin
            m_valid[port_idx] = 1;
            m_stat[port_idx]  = port_static;
            m_stamp[port_idx] = m_now;
            if (ls >= QD) m_lovf = 1; else lq.push_back(port_idx);
         end else if (m_valid[port_idx]) begin
            m_stamp[port_idx] = m_now;
         end
      end
      if (!m_busy && ((tick && cfg_auto_en) || cmd_age)) begin
         m_busy = 1; m_ptr = 0;
      end else if (step) begin
         if (m_ptr == N - 1) m_busy = 0;
         m_ptr = (m_ptr + 1) % N;
      end
      if (tick) begin m_pre = 0; m_now = (m_now + 1) % 512; end
      else m_pre++;
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      port_req = 0; port_learn = 0; port_static = 0; cmd_age = 0;
      lrn_rd = 0; aged_rd = 0;
   endtask

   task automatic learn(input int idx, input int st);
      port_req = 1; port_learn = 1; port_idx = IW'(idx); port_static = st[0];
      cyc();
      idle_inputs();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: explicit reset state
      #1;
      chk("R1 time after reset", int'(cur_time), 0);
      chk("R1 busy after reset", int'(age_busy), 0);
      chk("R1 entry invalid after reset", int'(qry_valid), 0);
      chk("R1 learned rvalid after reset", int'(lrn_rvalid), 0);
      chk("R1 overflow flags after reset", int'(lrn_ovf | aged_ovf), 0);

      // R3: learn all entries, 2 and 5 static
      for (int e = 0; e < N; e++) learn(e, (e == 2 || e == 5) ? 1 : 0);
      repeat (40) cyc();
      // R4: hit refreshes entry 1, hit on nothing else
      port_req = 1; port_learn = 0; port_idx = 3'd1; cyc(); idle_inputs();
      // R7/R8: commanded pass with walk priority, port keeps requesting
      cfg_threshold = 9'd1; cfg_auto_hi = 1;
      cmd_age = 1; cyc(); cmd_age = 0;
      port_req = 1; port_learn = 0; port_idx = 3'd4;
      for (int i = 0; i < 4; i++) begin
         #1 chk("R8 port refused while walk has priority", int'(port_gnt), 0);
         cyc();
      end
      idle_inputs();
      repeat (12) cyc();
      qry_idx = 3'd0; #1 chk("R5 stale entry 0 removed", int'(qry_valid), 0);
      qry_idx = 3'd2; #1 chk("R6 static entry 2 kept", int'(qry_valid), 1);
      qry_idx = 3'd1; #1 chk("R4 refreshed entry 1 kept", int'(qry_valid), 1);
      // R9: drain both queues, then R11 empty reads
      lrn_rd = 1; aged_rd = 1;
      repeat (QD + 3) cyc();
      idle_inputs(); cyc();
      #1 chk("R11 empty learned read gives no valid", int'(lrn_rvalid), 0);

      // R10: overflow the learned queue
      for (int i = 0; i < QD + 4; i++) learn(i % N, 0);
      #1 chk("R10 learned overflow flag set", int'(lrn_ovf), 1);
      lrn_rd = 1; repeat (QD + 2) cyc(); idle_inputs();

      // mixed traffic with automatic ageing and both priorities
      cfg_auto_en = 1; cfg_threshold = 9'd3;
      for (int c = 0; c < 11000; c++) begin
         cfg_auto_hi = ((c / 1500) % 2) == 1;
         if ((c % 3000) == 2000) cfg_threshold = 9'(c % 7);
         port_req    = ($urandom % 3) == 0;
         port_learn  = ($urandom % 4) == 0;
         port_static = ($urandom % 6) == 0;
         port_idx    = IW'($urandom % N);
         qry_idx     = IW'($urandom % N);
         cmd_age     = ($urandom % 50) == 0;
         lrn_rd      = ((c / 700) % 3 != 0) && ($urandom % 3) == 0;
         aged_rd     = ((c / 900) % 3 != 0) && ($urandom % 3) == 0;
         cyc();
      end
      idle_inputs(); cyc();

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule